// File: doc/BRIEF.md
# Partial-Reduction Multiply Sequencer for Binary Polynomials

This block multiplies two N-bit binary polynomials without carries and then folds the product back below degree N. The folding works modulo an irreducible polynomial M of degree m, with m at most N. M is not fixed when the block is built. Software writes a single fold constant, F = (M minus its leading term) shifted left by N−m, before a run of operations. The block never brings the result down to degree below m. It returns an N-bit polynomial that is congruent to a·b modulo M. Such results can be passed straight back in as operands, and only the last step of a longer computation needs a canonical reduction.

The product sits in a register 2N−1 bits wide. Its upper N−1 bits form the high word and its lower N bits form the low word. On every pass the low word is XOR-ed into an accumulator. If the high word is not zero, it is multiplied by F and the new product replaces the register. The loop stops on the first pass where the high word is zero. A pass counter limits the number of fold multiplies and aborts with an error if the limit is reached. The carry-less multiplier is built either as a one-cycle array or as a digit-serial engine, chosen by the DIGIT parameter.

Top module: `prdx_reducer`

## Requirements
- R1: While reset is asserted and right after it is released, busy, done and err are 0 and res is all zeros.
- R2: A start pulse while busy is 0 begins an operation on a_in and b_in, and busy reads 1 in the following cycle.
- R3: When done is 1, res equals the XOR of the low words from every pass, in this order: first the low word of a·b, then the low word of each high-word·F product. Reducing res modulo M gives the same value as reducing a·b modulo M.
- R4: The loop ends on the first pass whose high word is zero. Passes for a given input can be counted by running the product recurrence.
- R5: done is a one-cycle pulse, and busy is 0 in that cycle. res keeps its value after done until the next accepted start.
- R6: A start pulse while busy is 1 has no effect on the running operation or its result.
- R7: load_k copies k_in into the fold constant only while busy is 0. A load_k pulse while busy is 1 is ignored, including for later operations.
- R8: If the high word is still nonzero after MAX_ITER fold multiplies, the operation ends with a one-cycle err pulse in place of done. done and err are never 1 together.
- R9: Timing. Let S be 1 when DIGIT equals N, and N/DIGIT otherwise. Let L be 0 when DIGIT equals N, and S otherwise. An operation with i fold multiplies raises done on the (i+1)·(L+2)-th rising edge after the edge that accepts start. An abort raises err on edge (MAX_ITER+1)·(L+2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_k | input | 1 | Write k_in into the fold constant while idle |
| k_in | input | N | Fold constant F = (M − t^m)·t^(N−m) |
| start | input | 1 | Begin an operation while idle |
| a_in | input | N | First operand polynomial, bit i is the coefficient of t^i |
| b_in | input | N | Second operand polynomial |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: res holds the partially reduced product |
| err | output | 1 | One-cycle pulse: the pass limit was reached |
| res | output | N | Accumulated partially reduced result |

## Verification
The hardest case to reach is the abort. With a fold constant that comes from a valid M, the high word shrinks on every pass, so no legal operand drives the loop beyond MAX_ITER. The bench therefore sets MAX_ITER to 4 and loads the constant of a degree-17 polynomial whose second-highest term sits just one degree below the leading term. Each pass then lowers the high word by one degree at most, so random operands run past the limit. A separate mode pulses start and load_k with garbage partway through the fold loop. It then checks that neither the running result nor the following operation is affected.

// File: rtl/prdx_pkg.sv
package prdx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MUL  = 2'd1,
      ST_ACC  = 2'd2
   } prdx_state_e;
endpackage

// File: rtl/prdx_clmul.sv
module prdx_clmul #(
   parameter int N     = 64,
   parameter int DIGIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [N-1:0]     x,
   input  logic [N-1:0]     y,
   output logic             valid,
   output logic [2*N-2:0]   prod
);
   localparam int PW    = 2*N - 1;
   localparam int STEPS = (DIGIT >= N) ? 1 : N / DIGIT;
   localparam int CW    = $clog2(STEPS + 1);

   generate
      if (DIGIT >= N) begin : g_array
         function automatic logic [PW-1:0] full_mul(input logic [N-1:0] p, input logic [N-1:0] q);
            logic [PW-1:0] r;
            r = '0;
            for (int j = 0; j < N; j++)
               if (p[j]) r = r ^ ({{(N-1){1'b0}}, q} << j);
            return r;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid <= 1'b0;
               prod  <= '0;
            end else begin
               valid <= go;
               if (go) prod <= full_mul(x, y);
            end
         end
      end else begin : g_serial
         logic [N-1:0]  xs;
         logic [N-1:0]  ys;
         logic [PW-1:0] zacc;
         logic [CW-1:0] cnt;

         function automatic logic [PW-1:0] digit_mul(input logic [DIGIT-1:0] d, input logic [N-1:0] q);
            logic [PW-1:0] r;
            r = '0;
            for (int j = 0; j < DIGIT; j++)
               if (d[j]) r = r ^ ({{(N-1){1'b0}}, q} << j);
            return r;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               xs    <= '0;
               ys    <= '0;
               zacc  <= '0;
               cnt   <= '0;
               valid <= 1'b0;
            end else begin
               valid <= 1'b0;
               if (go) begin
                  xs   <= x;
                  ys   <= y;
                  zacc <= '0;
                  cnt  <= CW'(STEPS);
               end else if (cnt != '0) begin
                  zacc  <= (zacc << DIGIT) ^ digit_mul(xs[N-1 -: DIGIT], ys);
                  xs    <= xs << DIGIT;
                  cnt   <= cnt - 1'b1;
                  valid <= (cnt == CW'(1));
               end
            end
         end

         assign prod = zacc;
      end
   endgenerate
endmodule

// File: rtl/prdx_itercnt.sv
module prdx_itercnt #(
   parameter int MAX_ITER = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_max
);
   localparam int IW = $clog2(MAX_ITER + 1);
   logic [IW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign at_max = (cnt == IW'(MAX_ITER));
endmodule

// File: rtl/prdx_reducer.sv
module prdx_reducer
   import prdx_pkg::*;
#(
   parameter int N        = 64,
   parameter int DIGIT    = 16,
   parameter int MAX_ITER = N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_k,
   input  logic [N-1:0] k_in,
   input  logic         start,
   input  logic [N-1:0] a_in,
   input  logic [N-1:0] b_in,
   output logic         busy,
   output logic         done,
   output logic         err,
   output logic [N-1:0] res
);
   localparam int PW = 2*N - 1;

   generate
      if (N < 2)                                   begin : g_bad_n  $error("N must be at least 2");            end
      if (DIGIT < 1)                               begin : g_bad_d  $error("DIGIT must be positive");          end
      if (DIGIT < N && (N % DIGIT) != 0)           begin : g_bad_dn $error("DIGIT must divide N");             end
      if (MAX_ITER < 1)                            begin : g_bad_mx $error("MAX_ITER must be positive");       end
   endgenerate

   prdx_state_e   state;
   logic [N-1:0]  cst;
   logic [N-2:0]  rh;
   logic [N-1:0]  rl;
   logic [N-1:0]  acc;
   logic          done_q, err_q;

   logic          mul_go, mul_valid;
   logic [N-1:0]  mul_x, mul_y;
   logic [PW-1:0] mul_p;
   logic          at_max;
   logic          in_acc, hi_zero, fold_again, fold_abort, accept;

   assign in_acc     = (state == ST_ACC);
   assign hi_zero    = (rh == '0);
   assign accept     = (state == ST_IDLE) && start;
   assign fold_again = in_acc && !hi_zero && !at_max;
   assign fold_abort = in_acc && !hi_zero && at_max;
   assign mul_go     = accept || fold_again;
   assign mul_x      = (state == ST_IDLE) ? a_in : {1'b0, rh};
   assign mul_y      = (state == ST_IDLE) ? b_in : cst;

   prdx_clmul #(.N(N), .DIGIT(DIGIT)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (mul_go),
      .x     (mul_x),
      .y     (mul_y),
      .valid (mul_valid),
      .prod  (mul_p)
   );

   prdx_itercnt #(.MAX_ITER(MAX_ITER)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .inc    (fold_again),
      .at_max (at_max)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cst    <= '0;
         rh     <= '0;
         rl     <= '0;
         acc    <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (load_k) cst <= k_in;
               if (start) begin
                  acc   <= '0;
                  state <= ST_MUL;
               end
            end
            ST_MUL: begin
               if (mul_valid) begin
                  rh    <= mul_p[PW-1:N];
                  rl    <= mul_p[N-1:0];
                  state <= ST_ACC;
               end
            end
            ST_ACC: begin
               acc <= acc ^ rl;
               if (hi_zero) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (fold_abort) begin
                  err_q  <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  state  <= ST_MUL;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = done_q;
   assign err  = err_q;
   assign res  = acc;
endmodule

// File: rtl/prdx_reducer_chk.sv
module prdx_reducer_chk #(
   parameter int N = 64
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic         err,
   input logic [N-1:0] res
);
   p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(res));

   p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> (!busy && $past(busy)));

   p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !done);

   p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
endmodule

bind prdx_reducer prdx_reducer_chk #(.N(N)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .err   (err),
   .res   (res)
);

// File: tb/prdx_reducer_bench.sv
module prdx_reducer_bench;
   localparam int N    = 32;
   localparam int DG   = 8;
   localparam int MX   = 4;
   localparam int RND  = (N / DG) + 2;

   typedef struct {
      logic [N-1:0] res;
      logic         err;
      int           iters;
      int           edge0;
      logic [63:0]  m;
      int           deg;
      logic [62:0]  prod;
   } exp_t;

   logic clk = 0, rst_n = 0, load_k = 0, start = 0;
   logic [N-1:0] k_in = '0, a_in = '0, b_in = '0;
   logic busy, done, err;
   logic [N-1:0] res;

   int cyc = 0, n_chk = 0, n_bad = 0;
   exp_t q[$];
   logic [N-1:0] cur_k = '0;
   logic [63:0]  cur_m = '0;
   int           cur_deg = 1;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   prdx_reducer #(.N(N), .DIGIT(DG), .MAX_ITER(MX)) u_prdx_reducer (
      .clk(clk), .rst_n(rst_n), .load_k(load_k), .k_in(k_in), .start(start),
      .a_in(a_in), .b_in(b_in), .busy(busy), .done(done), .err(err), .res(res));

   function automatic logic [62:0] cm(input logic [N-1:0] x, input logic [N-1:0] y);
      logic [62:0] r = '0;
      for (int j = 0; j < N; j++) if (x[j]) r = r ^ ({31'b0, y} << j);
      return r;
   endfunction

   function automatic logic [63:0] pmod(input logic [63:0] v, input logic [63:0] m, input int deg);
      logic [63:0] r = v;
      for (int i = 63; i >= deg; i--) if (r[i]) r = r ^ (m << (i - deg));
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_poly(input logic [63:0] m, input int deg);
      logic [63:0] low;
      low = m & ~(64'd1 << deg);
      cur_m = m; cur_deg = deg;
      cur_k = N'(low << (N - deg));
      @(negedge clk); load_k = 1; k_in = cur_k;
      @(negedge clk); load_k = 0; k_in = '0;
   endtask

   task automatic op(input logic [N-1:0] a, input logic [N-1:0] b, input bit meddle);
      exp_t e;
      logic [62:0] p;
      logic [N-2:0] hi;
      p = cm(a, b);
      e.prod = p; e.m = cur_m; e.deg = cur_deg;
      e.res = p[N-1:0]; hi = p[62:N]; e.iters = 0; e.err = 0;
      while (hi != '0) begin
         if (e.iters == MX) begin e.err = 1; break; end
         p = cm({1'b0, hi}, cur_k);
         e.iters++;
         e.res = e.res ^ p[N-1:0];
         hi = p[62:N];
      end
      @(negedge clk);
      start = 1; a_in = a; b_in = b;
      e.edge0 = cyc + 1;
      q.push_back(e);
      @(negedge clk);
      start = 0;
      check(busy === 1'b1, "R2 busy after start", {63'b0, busy}, 64'd1);
      if (meddle) begin
         @(negedge clk);
         start = 1; a_in = ~a; b_in = b ^ 32'h5a5a_a5a5;   // R6 start while busy
         load_k = 1; k_in = ~cur_k;                       // R7 load while busy
         @(negedge clk);
         start = 0; load_k = 0; k_in = '0;
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      if (!e.err) check(res === e.res && !done, "R5 res held after done", {32'b0, res}, {32'b0, e.res});
   endtask

   // Monitor: scoreboard compare
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (done || err)) begin
            if (q.size() == 0) begin
               check(0, "R4 unexpected completion", {62'b0, done, err}, 0);
            end else begin
               exp_t e;
               int lat;
               e = q.pop_front();
               check(err === e.err && done === !e.err, "R8 done/err outcome",
                     {62'b0, done, err}, {62'b0, !e.err, e.err});
               lat = e.err ? (MX + 1) * RND : (e.iters + 1) * RND;
               check(cyc == e.edge0 + lat, "R9 R4 completion edge",
                     64'(cyc - e.edge0), 64'(lat));
               if (!e.err) begin
                  check(res === e.res, "R3 accumulated result", {32'b0, res}, {32'b0, e.res});
                  check(pmod({32'b0, res}, e.m, e.deg) == pmod({1'b0, e.prod}, e.m, e.deg),
                        "R3 congruent mod M", pmod({32'b0, res}, e.m, e.deg),
                        pmod({1'b0, e.prod}, e.m, e.deg));
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      wait (cyc > 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !err && res == '0, "R1 reset state", {29'b0, busy, done, err, res}, 0);
      rst_n = 1;
      @(negedge clk);
      check(!busy && !done && !err && res == '0, "R1 after release", {29'b0, busy, done, err, res}, 0);

      // m=29 trinomial
      set_poly((64'd1 << 29) | 64'h5, 29);
      op('0, 32'h1234_5678, 0);                 // R4 zero product, no folds
      op(32'h1, 32'h8000_0001, 0);
      op(32'hffff_ffff, 32'hffff_ffff, 0);
      for (int i = 0; i < 8; i++) op($urandom, $urandom, 0);
      op($urandom, $urandom, 1);                // R6 R7 meddling
      op($urandom, $urandom, 0);                // R7 constant unchanged afterwards

      // m=N pentanomial
      set_poly((64'd1 << 32) | 64'h8d, 32);
      for (int i = 0; i < 8; i++) op($urandom, $urandom, 0);
      op($urandom, $urandom, 1);

      // m=20, three folds possible
      set_poly((64'd1 << 20) | (64'd1 << 9) | 64'h9, 20);
      for (int i = 0; i < 8; i++) op($urandom, $urandom, 0);

      // m=17 with k=16: slow shrink forces R8 abort
      set_poly((64'd1 << 17) | (64'd1 << 16) | (64'd1 << 5) | 64'd1, 17);
      op(32'hffff_ffff, 32'hffff_ffff, 0);
      for (int i = 0; i < 4; i++) op($urandom, $urandom, 0);
      op(32'h3, 32'h5, 0);                      // small product still completes

      repeat (5) @(negedge clk);
      check(q.size() == 0, "R4 all operations completed", 64'(q.size()), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule